// File: doc/BRIEF.md
# Accumulator Shift Unit

This block shifts a wide accumulator word in one of five ways. Three shifts move the value by a fixed sixteen places: logical left, logical right and arithmetic right. Two shifts take their distance from a signed 16-bit amount word. The sign of that word sets the direction. A negative amount shifts left by its magnitude, and a zero or positive amount shifts right by its value. One of the variable shifts fills with zeros and the other fills with copies of the sign bit.

The datapath places the accumulator value, the amount word and an operation code on the inputs and raises `valid_i`. One clock later, the registered result appears on the outputs together with zero and negative flags, and carry and overflow are reported as clear. Choosing which register supplies the amount is left to the datapath around the block. On cycles with no valid request, the outputs keep their last values.

Top module: `acc_shifter`

## Requirements
- R1: During and straight after reset, `res_o` is zero, `valid_o`, `zero_o` and `neg_o` are low.
- R2: Operation code 0 returns the accumulator shifted left by 16, truncated to 40 bits, so the low 16 result bits are zero.
- R3: Operation code 1 shifts right by 16 and fills with zeros. Operation code 2 shifts right by 16 and fills with copies of accumulator bit 39.
- R4: Operation code 3 treats the accumulator as unsigned 40 bits. A negative amount `s` shifts left by `-s`, and a non-negative `s` shifts right by `s`. Both directions fill with zeros.
- R5: Operation code 4 is an arithmetic shift. A non-negative amount shifts right and fills with accumulator bit 39. A negative amount shifts left exactly as code 3 does.
- R6: A shift distance of 40 or more, in either direction and including an amount of -32768, gives zero. The one exception is an arithmetic right shift of a negative value, which gives all ones.
- R7: `zero_o` is high exactly when all 40 result bits are zero, and `neg_o` equals result bit 39.
- R8: `carry_o` and `ovf_o` are low after every operation.
- R9: A request taken with `valid_i` is reported one clock later with `valid_o` high. While `valid_i` is low, the result and the flags hold.
- R10: Operation codes 5, 6 and 7 return the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (0 to 4 are shifts, 5 to 7 pass the value through) |
| acc_i | input | 40 | Accumulator value |
| amt_i | input | 16 | Signed shift amount for the variable shifts |
| valid_o | output | 1 | Result valid, one cycle after the request |
| res_o | output | 40 | Shifted result |
| zero_o | output | 1 | Result equals zero |
| neg_o | output | 1 | Result bit 39 |
| carry_o | output | 1 | Carry flag, always clear |
| ovf_o | output | 1 | Overflow flag, always clear |

## Verification
The bench builds the block with its default parameters: a 40-bit accumulator, a 16-bit amount word and a fixed distance of 16. With these values the barrel shifter has six stages. Directed amounts of ±39, ±40, 32767 and -32768 land on both sides of the saturation threshold and at both extremes of the amount word. Random amounts are drawn partly from a narrow band around zero and partly from the full 16-bit range, so that each stage of the shifter is exercised and both fill policies are seen with each accumulator sign.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    OP_LSL_FIX = 3'd0,
    OP_LSR_FIX = 3'd1,
    OP_ASR_FIX = 3'd2,
    OP_LSH_VAR = 3'd3,
    OP_ASH_VAR = 3'd4
  } shf_op_e;

  typedef struct packed {
    logic left;
    logic fill;
    logic sat;
    logic bypass;
  } shf_ctrl_t;
endpackage

// File: rtl/shf_amt_dec.sv
// Signed amount -> direction, magnitude, saturation.
module shf_amt_dec #(
  parameter int AMT_W = 16,
  parameter int ACC_W = 40,
  parameter int SW    = 6
) (
  input  logic [AMT_W-1:0] amt_i,
  output logic             left_o,
  output logic [SW-1:0]    mag_o,
  output logic             sat_o
);
  localparam logic [AMT_W:0] LIMIT = (AMT_W+1)'(ACC_W);

  logic [AMT_W:0] mag_full;

  always_comb begin
    left_o   = amt_i[AMT_W-1];
    mag_full = left_o ? ({1'b0, ~amt_i} + (AMT_W+1)'(1)) : {1'b0, amt_i};
    sat_o    = (mag_full >= LIMIT);
    mag_o    = mag_full[SW-1:0];
  end
endmodule

// File: rtl/shf_barrel.sv
// Log-stage bidirectional shifter with fill bit and saturation.
module shf_barrel #(
  parameter int ACC_W = 40,
  parameter int SW    = 6
) (
  input  logic [ACC_W-1:0] data_i,
  input  logic [SW-1:0]    amt_i,
  input  logic             left_i,
  input  logic             fill_i,
  input  logic             sat_i,
  output logic [ACC_W-1:0] data_o
);
  logic [ACC_W-1:0] stage [SW+1];
  logic             rfill;

  assign rfill    = left_i ? 1'b0 : fill_i;
  assign stage[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [ACC_W-1:0] shl, shr;
    assign shl = {stage[k][ACC_W-1-SH:0], {SH{1'b0}}};
    assign shr = {{SH{rfill}}, stage[k][ACC_W-1:SH]};
    assign stage[k+1] = amt_i[k] ? (left_i ? shl : shr) : stage[k];
  end

  assign data_o = sat_i ? {ACC_W{rfill}} : stage[SW];
endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] res_i,
  output logic             zero_o,
  output logic             neg_o
);
  assign zero_o = ~|res_i;
  assign neg_o  = res_i[ACC_W-1];
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import shf_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int AMT_W  = 16,
  parameter int FIX_SH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] res_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int SW = $clog2(ACC_W);
  localparam logic [SW-1:0] FIX_AMT = SW'(FIX_SH);

  logic             var_left, var_sat;
  logic [SW-1:0]    var_mag;
  logic [SW-1:0]    sh_amt;
  shf_ctrl_t        ctrl;
  logic [ACC_W-1:0] sh_res, nxt_res;
  logic             nxt_zero, nxt_neg;
  logic             sign;

  assign sign = acc_i[ACC_W-1];

  shf_amt_dec #(.AMT_W(AMT_W), .ACC_W(ACC_W), .SW(SW)) u_dec (
    .amt_i  (amt_i),
    .left_o (var_left),
    .mag_o  (var_mag),
    .sat_o  (var_sat)
  );

  always_comb begin
    ctrl   = '{left: 1'b0, fill: 1'b0, sat: 1'b0, bypass: 1'b0};
    sh_amt = FIX_AMT;
    unique case (op_i)
      OP_LSL_FIX: ctrl.left = 1'b1;
      OP_LSR_FIX: ;
      OP_ASR_FIX: ctrl.fill = sign;
      OP_LSH_VAR: begin
        ctrl.left = var_left;
        ctrl.sat  = var_sat;
        sh_amt    = var_mag;
      end
      OP_ASH_VAR: begin
        ctrl.left = var_left;
        ctrl.fill = sign;
        ctrl.sat  = var_sat;
        sh_amt    = var_mag;
      end
      default: ctrl.bypass = 1'b1;
    endcase
  end

  shf_barrel #(.ACC_W(ACC_W), .SW(SW)) u_barrel (
    .data_i (acc_i),
    .amt_i  (sh_amt),
    .left_i (ctrl.left),
    .fill_i (ctrl.fill),
    .sat_i  (ctrl.sat),
    .data_o (sh_res)
  );

  assign nxt_res = ctrl.bypass ? acc_i : sh_res;

  shf_flags #(.ACC_W(ACC_W)) u_flags (
    .res_i  (nxt_res),
    .zero_o (nxt_zero),
    .neg_o  (nxt_neg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      zero_o  <= 1'b0;
      neg_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o  <= nxt_res;
        zero_o <= nxt_zero;
        neg_o  <= nxt_neg;
      end
    end
  end

  // shifts never carry or overflow
  assign carry_o = 1'b0;
  assign ovf_o   = 1'b0;
endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
  parameter int ACC_W  = 40,
  parameter int AMT_W  = 16,
  parameter int FIX_SH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [AMT_W-1:0] amt_i,
  input logic             valid_o,
  input logic [ACC_W-1:0] res_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             carry_o,
  input logic             ovf_o
);
  p_lsl_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0) |=> (res_o[FIX_SH-1:0] == '0));

  p_asr_sign_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2) |=>
      (res_o[ACC_W-1 -: FIX_SH+1] == {(FIX_SH+1){$past(acc_i[ACC_W-1])}}));

  p_far_right_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && !amt_i[AMT_W-1] && amt_i >= AMT_W'(ACC_W)) |=> (res_o == '0));

  p_zero_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zero_o == (res_o == '0)));

  p_neg_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (neg_o == res_o[ACC_W-1]));

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && !valid_o));

  p_pass_through_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 3'd5) |=> (res_o == $past(acc_i)));

  p_flags_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(carry_o || ovf_o));
endmodule

bind acc_shifter shf_checker #(.ACC_W(ACC_W), .AMT_W(AMT_W), .FIX_SH(FIX_SH)) u_chk (.*);

// File: tb/sim_acc_shifter.sv
module sim_acc_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 40;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [W-1:0]  acc_i = '0;
  logic [15:0]   amt_i = '0;
  logic          valid_o, zero_o, neg_o, carry_o, ovf_o;
  logic [W-1:0]  res_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  acc_shifter u0 (.*);

  function automatic logic [W-1:0] ref_model(logic [2:0] op, logic [W-1:0] a, logic [15:0] s);
    longint unsigned d = 64'({24'b0, a});
    longint sd = longint'({{24{a[W-1]}}, a});
    logic [63:0] r;
    int n;
    n = s[15] ? (0 - int'($signed(s))) : int'(s);
    case (op)
      3'd0: r = d << 16;
      3'd1: r = d >> 16;
      3'd2: r = 64'(sd >>> 16);
      3'd3, 3'd4: begin
        if (s[15])          r = (n >= W) ? 64'd0 : (d << n);
        else if (op == 3'd3) r = (n >= W) ? 64'd0 : (d >> n);
        else                r = (n >= W) ? (a[W-1] ? '1 : 64'd0) : 64'(sd >>> n);
      end
      default: r = d;
    endcase
    return r[W-1:0];
  endfunction

  function automatic string req_of(logic [2:0] op, logic [15:0] s);
    int n = s[15] ? (0 - int'($signed(s))) : int'(s);
    if (op >= 3'd3 && op <= 3'd4 && n >= W) return "R6";
    case (op)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(logic [2:0] op, logic [W-1:0] a, logic [15:0] s);
    logic [W-1:0] exp;
    string r;
    exp = ref_model(op, a, s);
    r = req_of(op, s);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; acc_i = a; amt_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(r, "result", 64'(res_o), 64'(exp));
    check("R7", "zero flag", 64'(zero_o), 64'(exp == '0));
    check("R7", "neg flag", 64'(neg_o), 64'(exp[W-1]));
    check("R8", "carry/ovf", 64'({carry_o, ovf_o}), 64'd0);
    check("R9", "valid_o", 64'(valid_o), 64'd1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 3);
    // R1 reset state
    check("R1", "reset res", 64'(res_o), 64'd0);
    check("R1", "reset flags", 64'({valid_o, zero_o, neg_o}), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "after reset valid", 64'(valid_o), 64'd0);

    // directed corners
    run_op(3'd0, 40'hFF_1234_5678, 16'h0);
    run_op(3'd1, 40'h80_0000_FFFF, 16'h0);
    run_op(3'd2, 40'h80_0000_FFFF, 16'h0);
    run_op(3'd2, 40'h7F_FFFF_0000, 16'h0);
    run_op(3'd3, 40'h00_0000_0001, 16'hFFD9); // -39
    run_op(3'd3, 40'h00_0000_0001, 16'hFFD8); // -40
    run_op(3'd3, 40'h80_0000_0000, 16'd39);
    run_op(3'd3, 40'hFF_FFFF_FFFF, 16'd40);
    run_op(3'd4, 40'h80_0000_0000, 16'd39);
    run_op(3'd4, 40'h80_0000_0000, 16'd40);
    run_op(3'd4, 40'h80_0000_0000, 16'h7FFF);
    run_op(3'd4, 40'h40_0000_0001, 16'h8000); // -32768
    run_op(3'd3, 40'h12_3456_789A, 16'h8000);
    run_op(3'd4, 40'h81_0000_0003, 16'hFFFF);
    run_op(3'd3, 40'hC3_0000_1234, 16'd0);
    run_op(3'd5, 40'h80_0000_0000, 16'd3);
    run_op(3'd7, 40'h00_0000_0000, 16'hFFFF);

    // R9 hold: inputs change without valid_i
    held = res_o;
    @(negedge clk_i);
    op_i = 3'd0; acc_i = 40'hAA_5555_AAAA;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9", "hold res", 64'(res_o), 64'(held));
    check("R9", "hold valid", 64'(valid_o), 64'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0]   op = 3'($urandom_range(0, 7));
      logic [W-1:0] a  = {8'($urandom), 32'($urandom)};
      logic [15:0]  s  = (i % 2 == 0) ? 16'($signed($urandom_range(0, 100)) - 50) : 16'($urandom);
      run_op(op, a, s);
    end

    done = 1;
    finish_run();
  end
endmodule